// File: doc/BRIEF.md
# Indirect Nibble Add-With-Carry Executor

This block carries out one family of 13-bit instructions on a 4-bit data path. Each instruction reads a nibble from data memory, adds a 4-bit immediate field and the current carry flag, and writes the 4-bit result back to the same location. The location comes from one of two 16-bit index registers. The block reports the new carry and zero flags and clears the extension flag. It can also advance the chosen index register by one after the update.

When the extension flag is set, the non-incrementing forms ignore the index register. They address a fixed page instead: page 0x00 for the X form and page 0xFF for the Y form. The low byte of the address comes from an 8-bit extension value. The post-increment forms always use the index register.

The architectural registers (X, Y, the extension byte and the flags) live outside the block. The block reads them when an instruction starts. It returns new values through write-enable strobes, which the register file applies on the next clock edge. Data memory is a synchronous nibble-wide port with one cycle of read latency.

Top module: `nibadc_exec`

## Requirements
- R1: An instruction is legal only when instr[12:6] = 1100110, which covers 0x1980 to 0x19BF. In a legal instruction, instr[5] selects the index (0 = X, 1 = Y), instr[4] = 1 selects post-increment, and instr[3:0] is the immediate. A start with any other code raises `illegal` for exactly one cycle, in the cycle after the start edge. It produces no memory access, no flag write and no index write.
- R2: A legal instruction accepted on a clock edge drives `mem_rd` with the target address in the next cycle. In the cycle after that it drives `mem_wr`, `done` and `flags_we` together at the same address. `busy` is high for exactly those two cycles.
- R3: The written nibble is (mem + imm + C) mod 16, where C is the carry flag sampled at the start edge.
- R4: `c_next` is the carry out of that 5-bit sum.
- R5: `z_next` is 1 exactly when the written nibble is 0.
- R6: `e_next` is 0 whenever `flags_we` is high, so every executed instruction clears the extension flag.
- R7: When E is 1 for a non-incrementing X form (0x1980 to 0x198F), the target is 0x0000 plus the extension byte.
- R8: When E is 1 for a non-incrementing Y form (0x19A0 to 0x19AF), the target is 0xFF00 plus the extension byte.
- R9: The post-increment forms ignore the extension byte even when E is 1, and address through the selected index register.
- R10: In a post-increment form, the selected index receives its start value plus 1, modulo 2^16, in the write cycle. The other index is untouched. The increment has no effect on C or Z.
- R11: A start while `busy` is high is ignored. The start input is sampled again only once the block is idle.
- R12: In reset and straight after it, all strobes (`busy`, `mem_rd`, `mem_wr`, `done`, `illegal`, `flags_we`, `idx_we_x`, `idx_we_y`) are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin executing `instr` at this edge when idle |
| instr | input | 13 | Instruction word |
| idx_x | input | 16 | Current X index register |
| idx_y | input | 16 | Current Y index register |
| ext_val | input | 8 | Current extension byte |
| flag_c | input | 1 | Current carry flag |
| flag_e | input | 1 | Current extension flag |
| mem_addr | output | 16 | Data memory address |
| mem_rd | output | 1 | Read strobe; data is returned on the next cycle |
| mem_rdata | input | 4 | Read data, valid in the cycle after `mem_rd` |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 4 | Write data |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | Final cycle of a legal instruction |
| illegal | output | 1 | One-cycle pulse for an unrecognised code |
| flags_we | output | 1 | Load `c_next`, `z_next` and `e_next` into the flags |
| c_next | output | 1 | New carry flag |
| z_next | output | 1 | New zero flag |
| e_next | output | 1 | New extension flag |
| idx_we_x | output | 1 | Load `idx_next` into X |
| idx_we_y | output | 1 | Load `idx_next` into Y |
| idx_next | output | 16 | Incremented index value |

## Verification
Some properties are checked on every cycle:
- the strobe sequence, in which a read is followed by a write at an unchanged address and then a return to idle;
- the silence of an illegal pulse;
- the single, exclusive index write that coincides with `done`;
- the agreement between the zero flag and the written nibble.

Other behaviour depends on data and history, and only the bench scenarios show it:
- the arithmetic itself;
- the carry out;
- the page override with its two page values;
- the rule that post-increment ignores the extension;
- the index wrap from 0xFFFF to 0x0000;
- the discarding of a start held through a busy instruction.

// File: rtl/nibadc_pkg.sv
// Shared definitions for the nibble add-with-carry executor.
// Assumes a 13-bit instruction: 7-bit family head, select, increment, 4-bit immediate.
package nibadc_pkg;
    localparam int          DATA_W  = 4;
    localparam int          OP_W    = 13;
    localparam int          HEAD_W  = 7;
    localparam logic [6:0]  OP_HEAD = 7'b1100110;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_BAD   = 2'd3
    } nibadc_state_e;

    typedef struct packed {
        logic              legal;
        logic              sel_y;
        logic              post_inc;
        logic [DATA_W-1:0] imm;
    } nibadc_op_t;
endpackage

// File: rtl/nibadc_decode.sv
// Instruction decoder: splits the opcode into fields and flags the family match.
// Assumes IW = HEAD_W + 2 + DATA_W; purely combinational.
module nibadc_decode
    import nibadc_pkg::*;
#(
    parameter int IW = OP_W
) (
    input  logic [IW-1:0] instr,
    output nibadc_op_t    op
);
    localparam int HEAD_LSB = IW - HEAD_W;
    localparam int SEL_BIT  = HEAD_LSB - 1;
    localparam int INC_BIT  = HEAD_LSB - 2;

    // Field extraction and family match
    always_comb begin
        op.legal    = (instr[IW-1:HEAD_LSB] == OP_HEAD);
        op.sel_y    = instr[SEL_BIT];
        op.post_inc = instr[INC_BIT];
        op.imm      = instr[DATA_W-1:0];
    end
endmodule

// File: rtl/nibadc_addr.sv
// Target address generator: picks the index register, or a fixed page plus the
// extension byte when extension is active on a non-incrementing form.
// Assumes PW < AW; the X page is all zeros and the Y page is all ones.
module nibadc_addr #(
    parameter int AW = 16,
    parameter int PW = 8
) (
    input  logic          sel_y,
    input  logic          post_inc,
    input  logic          ext_on,
    input  logic [PW-1:0] ext,
    input  logic [AW-1:0] x,
    input  logic [AW-1:0] y,
    output logic [AW-1:0] target,
    output logic [AW-1:0] index
);
    localparam int            HW      = AW - PW;
    localparam logic [HW-1:0] PAGE_LO = '0;
    localparam logic [HW-1:0] PAGE_HI = '1;

    // Index selection and page override
    always_comb begin
        index = sel_y ? y : x;
        if (ext_on && !post_inc) begin
            target = {(sel_y ? PAGE_HI : PAGE_LO), ext};
        end else begin
            target = index;
        end
    end
endmodule

// File: rtl/nibadc_alu.sv
// Ripple adder for the nibble path: sum of two operands plus carry in, with
// carry out and a zero indication on the truncated sum.
// Assumes DW is small; the ripple depth grows linearly with it.
module nibadc_alu #(
    parameter int DW = 4
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    output logic [DW-1:0] sum,
    output logic          cout,
    output logic          zero
);
    logic [DW:0] cy;

    assign cy[0] = cin;

    for (genvar i = 0; i < DW; i++) begin : g_bit
        // Full-adder cell for bit i
        assign sum[i]  = a[i] ^ b[i] ^ cy[i];
        assign cy[i+1] = (a[i] & b[i]) | (a[i] & cy[i]) | (b[i] & cy[i]);
    end

    assign cout = cy[DW];
    assign zero = ~|sum;
endmodule

// File: rtl/nibadc_exec.sv
// Executor top: accepts one instruction when idle, reads the target nibble in
// the first cycle, writes the sum and presents the flag and index updates in
// the second cycle. Unknown codes produce a one-cycle illegal pulse only.
// Assumes a synchronous memory with one-cycle read latency and an external
// register file that applies the *_we strobes on the following edge.
module nibadc_exec
    import nibadc_pkg::*;
#(
    parameter int AW = 16,
    parameter int PW = 8,
    parameter int DW = DATA_W,
    parameter int IW = OP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [IW-1:0] instr,
    input  logic [AW-1:0] idx_x,
    input  logic [AW-1:0] idx_y,
    input  logic [PW-1:0] ext_val,
    input  logic          flag_c,
    input  logic          flag_e,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    output logic          busy,
    output logic          done,
    output logic          illegal,
    output logic          flags_we,
    output logic          c_next,
    output logic          z_next,
    output logic          e_next,
    output logic          idx_we_x,
    output logic          idx_we_y,
    output logic [AW-1:0] idx_next
);
    localparam logic [AW-1:0] IDX_STEP = AW'(1);

    nibadc_state_e state_q;
    nibadc_op_t    op;
    logic [AW-1:0] tgt;
    logic [AW-1:0] idx_sel;
    logic          sel_q;
    logic          inc_q;
    logic [DW-1:0] imm_q;
    logic          cin_q;
    logic [AW-1:0] addr_q;
    logic [AW-1:0] idx_q;
    logic          accept;

    nibadc_decode #(.IW(IW)) u_dec (
        .instr (instr),
        .op    (op)
    );

    nibadc_addr #(.AW(AW), .PW(PW)) u_addr (
        .sel_y    (op.sel_y),
        .post_inc (op.post_inc),
        .ext_on   (flag_e),
        .ext      (ext_val),
        .x        (idx_x),
        .y        (idx_y),
        .target   (tgt),
        .index    (idx_sel)
    );

    nibadc_alu #(.DW(DW)) u_alu (
        .a    (mem_rdata),
        .b    (imm_q),
        .cin  (cin_q),
        .sum  (mem_wdata),
        .cout (c_next),
        .zero (z_next)
    );

    // Start is honoured only from idle
    assign accept = start && (state_q == ST_IDLE);

    // Sequencer: idle -> read -> write -> idle, or idle -> bad -> idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (accept) state_q <= op.legal ? ST_READ : ST_BAD;
                ST_READ:  state_q <= ST_WRITE;
                ST_WRITE: state_q <= ST_IDLE;
                ST_BAD:   state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Operand capture at the accepting edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= 1'b0;
            inc_q  <= 1'b0;
            imm_q  <= '0;
            cin_q  <= 1'b0;
            addr_q <= '0;
            idx_q  <= '0;
        end else if (accept && op.legal) begin
            sel_q  <= op.sel_y;
            inc_q  <= op.post_inc;
            imm_q  <= op.imm;
            cin_q  <= flag_c;
            addr_q <= tgt;
            idx_q  <= idx_sel;
        end
    end

    // Strobes decoded from the sequencer state
    always_comb begin
        busy     = (state_q != ST_IDLE);
        mem_rd   = (state_q == ST_READ);
        mem_wr   = (state_q == ST_WRITE);
        done     = (state_q == ST_WRITE);
        flags_we = (state_q == ST_WRITE);
        illegal  = (state_q == ST_BAD);
        e_next   = 1'b0;
        idx_we_x = (state_q == ST_WRITE) && inc_q && !sel_q;
        idx_we_y = (state_q == ST_WRITE) && inc_q && sel_q;
    end

    // Address and index result paths
    assign mem_addr = addr_q;
    assign idx_next = idx_q + IDX_STEP;
endmodule

// File: rtl/nibadc_chk.sv
// Protocol checker for the executor: strobe ordering, illegal silence,
// index-write exclusivity and zero-flag consistency. Attached by bind.
module nibadc_chk #(
    parameter int AW = 16,
    parameter int DW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          done,
    input logic          illegal,
    input logic          flags_we,
    input logic          z_next,
    input logic          idx_we_x,
    input logic          idx_we_y
);
    // R2
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (mem_wr && $stable(mem_addr)));

    // R2
    wr_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> (!busy && !mem_rd && !mem_wr));

    // R11
    rd_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> ($past(start) && !$past(busy)));

    // R1
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!mem_rd && !mem_wr && !flags_we && !idx_we_x && !idx_we_y));

    // R1
    illegal_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> !illegal);

    // R10
    idx_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_we_x || idx_we_y) |-> (done && $onehot0({idx_we_x, idx_we_y})));

    // R5
    zero_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags_we |-> (z_next == (mem_wdata == '0)));
endmodule

bind nibadc_exec nibadc_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .done      (done),
    .illegal   (illegal),
    .flags_we  (flags_we),
    .z_next    (z_next),
    .idx_we_x  (idx_we_x),
    .idx_we_y  (idx_we_y)
);

// File: tb/tb_nibadc_exec.sv
// Bench: behavioural register file and memory, a phase-tracking reference
// model compared at every falling edge, and directed scenarios.
module tb_nibadc_exec;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [12:0] instr;
    logic [15:0] rx, ry;
    logic [7:0]  rext;
    logic        rc, rz, re;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [3:0]  mem_rdata, mem_wdata;
    logic        busy, done, illegal, flags_we;
    logic        c_next, z_next, e_next;
    logic        idx_we_x, idx_we_y;
    logic [15:0] idx_next;

    int checks = 0;
    int errors = 0;
    bit running = 0;

    logic [3:0] mem [int];

    always #10 clk = ~clk;

    nibadc_exec dut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .idx_x(rx), .idx_y(ry), .ext_val(rext), .flag_c(rc), .flag_e(re),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .busy(busy), .done(done),
        .illegal(illegal), .flags_we(flags_we), .c_next(c_next),
        .z_next(z_next), .e_next(e_next), .idx_we_x(idx_we_x),
        .idx_we_y(idx_we_y), .idx_next(idx_next)
    );

    function automatic logic [3:0] peek(int a);
        return mem.exists(a) ? mem[a] : 4'h0;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Environment: memory and architectural registers
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= peek(int'(mem_addr));
        if (mem_wr) mem[int'(mem_addr)] = mem_wdata;
        if (rst_n && flags_we) begin rc <= c_next; rz <= z_next; re <= e_next; end
        if (rst_n && idx_we_x) rx <= idx_next;
        if (rst_n && idx_we_y) ry <= idx_next;
    end

    // Reference model: 0 idle, 1 read, 2 write, 3 illegal
    int         ph = 0;
    int         m_addr, m_idx, m_imm;
    bit         m_sel, m_inc, m_c;
    always @(posedge clk) begin
        if (!rst_n) ph = 0;
        else case (ph)
            0: if (start) begin
                   if (int'(instr) >= 'h1980 && int'(instr) <= 'h19BF) begin
                       m_sel = int'(instr) >= 'h19A0;
                       m_inc = instr[4];
                       m_imm = int'(instr) % 16;
                       m_c   = rc;
                       m_idx = m_sel ? int'(ry) : int'(rx);
                       if (re && !m_inc) m_addr = m_sel ? ('hFF00 + int'(rext)) : int'(rext);
                       else              m_addr = m_idx;
                       ph = 1;
                   end else ph = 3;
               end
            1: ph = 2;
            default: ph = 0;
        endcase
    end

    // Cycle-by-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (running && rst_n) begin
            int s;
            chk(busy == (ph != 0), "R2", "busy", busy, ph != 0);
            chk(mem_rd == (ph == 1), "R2", "mem_rd", mem_rd, ph == 1);
            chk(mem_wr == (ph == 2), "R2", "mem_wr", mem_wr, ph == 2);
            chk(done == (ph == 2), "R2", "done", done, ph == 2);
            chk(illegal == (ph == 3), "R1", "illegal", illegal, ph == 3);
            if (ph == 1 || ph == 2)
                chk(int'(mem_addr) == m_addr, "R7/R8/R9", "mem_addr", mem_addr, m_addr);
            if (ph == 2) begin
                s = int'(peek(m_addr)) + m_imm + int'(m_c);
                chk(int'(mem_wdata) == s % 16, "R3", "wdata", mem_wdata, s % 16);
                chk(c_next == (s > 15), "R4", "c_next", c_next, s > 15);
                chk(z_next == (s % 16 == 0), "R5", "z_next", z_next, s % 16 == 0);
                chk(flags_we && !e_next, "R6", "flags_we/e_next", {flags_we, e_next}, 2);
                chk(idx_we_x == (m_inc && !m_sel), "R10", "idx_we_x", idx_we_x, m_inc && !m_sel);
                chk(idx_we_y == (m_inc && m_sel), "R10", "idx_we_y", idx_we_y, m_inc && m_sel);
                if (m_inc)
                    chk(int'(idx_next) == (m_idx + 1) % 65536, "R10", "idx_next", idx_next, (m_idx + 1) % 65536);
            end else begin
                chk(!flags_we && !idx_we_x && !idx_we_y, "R1", "quiet strobes",
                    {flags_we, idx_we_x, idx_we_y}, 0);
            end
        end
    end

    task automatic run_op(logic [12:0] code);
        @(negedge clk); start = 1'b1; instr = code;
        @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; instr = '0;
        rx = '0; ry = '0; rext = '0; rc = 0; rz = 0; re = 0; mem_rdata = '0;
        repeat (3) @(negedge clk);
        // R12: strobes low in reset
        chk({busy, mem_rd, mem_wr, done, illegal, flags_we, idx_we_x, idx_we_y} == 0,
            "R12", "reset strobes", {busy, mem_rd, mem_wr, done, illegal}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, mem_rd, mem_wr, done, illegal, flags_we} == 0, "R12", "post-reset strobes", busy, 0);
        running = 1;

        // R3: plain X form
        rx = 16'h0123; mem['h0123] = 4'h5; rc = 1;
        run_op(13'h1983);
        chk(peek('h0123) == 4'h9, "R3", "mem x", peek('h0123), 9);
        chk(rc == 0 && rz == 0, "R4", "flags x", {rc, rz}, 0);

        // R4: carry out from Y form
        ry = 16'h4000; mem['h4000] = 4'hF; rc = 1;
        run_op(13'h19AF);
        chk(peek('h4000) == 4'hF, "R3", "mem y", peek('h4000), 15);
        chk(rc == 1, "R4", "carry", rc, 1);

        // R5: zero result
        rx = 16'h0010; mem['h0010] = 4'h8; rc = 0;
        run_op(13'h1988);
        chk(rz == 1 && rc == 1, "R5", "zero+carry", {rc, rz}, 3);

        // R7: extended X page
        rx = 16'h7777; mem['h7777] = 4'h0; rext = 8'h5A; mem['h005A] = 4'h2; re = 1; rc = 0;
        run_op(13'h1981);
        chk(peek('h005A) == 4'h3, "R7", "ext x mem", peek('h005A), 3);
        chk(peek('h7777) == 4'h0, "R7", "index untouched", peek('h7777), 0);
        chk(re == 0, "R6", "e cleared", re, 0);

        // R8: extended Y page
        rext = 8'h33; mem['hFF33] = 4'h4; re = 1; rc = 0;
        run_op(13'h19A2);
        chk(peek('hFF33) == 4'h6, "R8", "ext y mem", peek('hFF33), 6);

        // R9: post-increment ignores extension
        rext = 8'h11; mem['h0011] = 4'h0; rx = 16'h0200; mem['h0200] = 4'h1; re = 1; rc = 0;
        run_op(13'h1994);
        chk(peek('h0200) == 4'h5, "R9", "index used", peek('h0200), 5);
        chk(peek('h0011) == 4'h0, "R9", "ext page untouched", peek('h0011), 0);
        chk(rx == 16'h0201, "R10", "x incremented", rx, 'h201);
        chk(re == 0, "R6", "e cleared inc", re, 0);

        // R10: Y wrap, flags follow the data only
        ry = 16'hFFFF; mem['hFFFF] = 4'h1; rc = 0; rx = 16'h0AAA;
        run_op(13'h19B0);
        chk(ry == 16'h0000, "R10", "y wrap", ry, 0);
        chk(rz == 0 && rc == 0, "R10", "flags unaffected by wrap", {rc, rz}, 0);
        chk(rx == 16'h0AAA, "R10", "x untouched", rx, 'hAAA);

        // R1: illegal codes change nothing
        for (int k = 0; k < 3; k++) begin
            logic [12:0] bad;
            bad = (k == 0) ? 13'h19C5 : (k == 1) ? 13'h1975 : 13'h0000;
            rx = 16'h0055; mem['h0055] = 4'h7; re = 1; rc = 1;
            run_op(bad);
            chk(peek('h0055) == 4'h7 && rx == 16'h0055 && re == 1 && rc == 1,
                "R1", "illegal no effect", peek('h0055), 7);
        end

        // R11: start held high across a busy instruction
        rx = 16'h0300; mem['h0300] = 4'h0; re = 0; rc = 0;
        @(negedge clk); start = 1'b1; instr = 13'h1981;
        repeat (5) @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        chk(peek('h0300) == 4'h2, "R11", "two accepted ops", peek('h0300), 2);

        running = 0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule